// File: doc/BRIEF.md
# Batch Multiply-Add Pipeline

This block evaluates `A*B + C` for a fixed-length batch of operand triples held in three small internal operand stores. A start pulse launches the batch. A sequencer then issues one triple per clock into a pipeline of three register-separated segments:

- The first segment captures the A and B operands.
- The second segment forms their product and captures the matching C operand, which reaches it one clock after its A and B.
- The third segment adds the product to C and registers the sum.

Each result leaves with a valid flag and the index of its task. After the last result, a one-clock done pulse marks the end of the batch. At the same moment a cycle counter shows how many clocks the batch occupied the pipeline.

A simple write port fills the operand stores while the block is idle. A batch of N tasks therefore takes N+2 clocks from the first segment load to the last registered result. Once the pipeline is full it delivers one result per clock.

Top module: `mac_batch_top`

## Requirements
- R1: After reset, `res_valid` and `done` are 0 and `cycles` is 0. They stay that way until a start pulse is accepted.
- R2: Every valid result equals the A, B and C operands stored at index `res_idx`, combined as A*B+C. The product is unsigned and the sum is exact in 17 bits. For example 255*255+65535 gives 130560.
- R3: If `start` is sampled high while the block is idle on clock edge E0, the first result (index 0) is presented with `res_valid` high after edge E3.
- R4: A batch yields exactly N valid results, one per clock on consecutive clocks. Their indices run 0, 1, ..., N-1 in order. `res_valid` is low at all other times.
- R5: `done` is high for exactly one clock, in the cycle right after the last valid result.
- R6: While `done` is high, `cycles` equals N+2. This is the count of clocks from the first segment load to the last result load. The value holds until the next batch starts.
- R7: A start pulse while a batch is being issued is ignored. The results of the running batch keep the R3/R4 timing and R2 values.
- R8: A write with `wr_en` high stores `wr_a`, `wr_b` and `wr_c` at index `wr_idx`. The next batch uses those values for task `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Operand store write strobe |
| wr_idx | input | 3 | Task index to write |
| wr_a | input | 8 | A operand to store |
| wr_b | input | 8 | B operand to store |
| wr_c | input | 16 | C operand to store |
| start | input | 1 | Begin a batch (accepted only when idle) |
| res_valid | output | 1 | Result valid |
| res_idx | output | 3 | Task index of the result |
| res_data | output | 17 | A*B+C |
| done | output | 1 | One-clock pulse after the last result |
| cycles | output | 4 | Clocks used by the last batch |

## Verification
Corruption of a segment valid bit appears at `res_valid` within three clocks, as a missing or extra result. It also shifts the moment `done` rises and the final `cycles` value.

A C operand that is paired with the wrong task appears in the very first result as a wrong sum. If the sequencer index drifts, the next result carries a wrong `res_idx` and a value taken from the wrong operand slot. Each of these errors is visible within one batch of N+3 clocks.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned DEF_TASKS = 7;
  localparam int unsigned DEF_AB_W  = 8;
  localparam int unsigned DEF_C_W   = 16;

  function automatic int unsigned sum_width(input int unsigned ab_w, input int unsigned c_w);
    int unsigned pw;
    pw = 2 * ab_w;
    return ((pw > c_w) ? pw : c_w) + 1;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int unsigned N    = DEF_TASKS,
  parameter int unsigned AB_W = DEF_AB_W,
  parameter int unsigned C_W  = DEF_C_W,
  localparam int unsigned IW  = idx_width(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [AB_W-1:0] wr_a,
  input  logic [AB_W-1:0] wr_b,
  input  logic [C_W-1:0]  wr_c,
  input  logic            start,
  output logic            start_acc,
  output logic            issue_v,
  output logic [IW-1:0]   issue_idx,
  output logic [AB_W-1:0] issue_a,
  output logic [AB_W-1:0] issue_b,
  output logic [C_W-1:0]  late_c
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [AB_W-1:0] store_a [N];
  logic [AB_W-1:0] store_b [N];
  logic [C_W-1:0]  store_c [N];

  logic          run_q, run_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] cidx_q, cidx_d;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_a[wr_idx] <= wr_a;
      store_b[wr_idx] <= wr_b;
      store_c[wr_idx] <= wr_c;
    end
  end

  always_comb begin
    run_d     = run_q;
    idx_d     = idx_q;
    start_acc = 1'b0;
    if (!run_q) begin
      if (start) begin
        run_d     = 1'b1;
        idx_d     = '0;
        start_acc = 1'b1;
      end
    end else if (idx_q == LAST) begin
      run_d = 1'b0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
    cidx_d = run_q ? idx_q : cidx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      cidx_q <= '0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      cidx_q <= cidx_d;
    end
  end

  assign issue_v   = run_q;
  assign issue_idx = idx_q;
  assign issue_a   = store_a[idx_q];
  assign issue_b   = store_b[idx_q];
  assign late_c    = store_c[cidx_q];

  // R7
  idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (idx_q == IW'($past(idx_q) + 1'b1)));
endmodule

// File: rtl/mac_pipe3.sv
module mac_pipe3
  import mac_pkg::*;
#(
  parameter int unsigned N    = DEF_TASKS,
  parameter int unsigned AB_W = DEF_AB_W,
  parameter int unsigned C_W  = DEF_C_W,
  localparam int unsigned IW  = idx_width(N),
  localparam int unsigned RW  = sum_width(AB_W, C_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [IW-1:0]   in_idx,
  input  logic [AB_W-1:0] in_a,
  input  logic [AB_W-1:0] in_b,
  input  logic [C_W-1:0]  in_c,
  output logic            inner_busy,
  output logic            out_v,
  output logic [IW-1:0]   out_idx,
  output logic [RW-1:0]   out_sum
);
  // segment 1
  logic            v1_q;
  logic [AB_W-1:0] ra_q, rb_q;
  logic [IW-1:0]   i1_q;
  // segment 2
  logic            v2_q;
  logic [RW-1:0]   prod_q;
  logic [C_W-1:0]  rc_q;
  logic [IW-1:0]   i2_q;
  // segment 3
  logic            v3_q;
  logic [RW-1:0]   sum_q;
  logic [IW-1:0]   i3_q;

  logic [RW-1:0]   prod_d, sum_d;

  always_comb begin
    prod_d = RW'(ra_q) * RW'(rb_q);
    sum_d  = prod_q + RW'(rc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_v;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      ra_q <= in_a;
      rb_q <= in_b;
      i1_q <= in_idx;
    end
    if (v1_q) begin
      prod_q <= prod_d;
      rc_q   <= in_c;
      i2_q   <= i1_q;
    end
    if (v2_q) begin
      sum_q <= sum_d;
      i3_q  <= i2_q;
    end
  end

  assign inner_busy = v1_q | v2_q;
  assign out_v      = v3_q;
  assign out_idx    = i3_q;
  assign out_sum    = sum_q;

  // R2
  seg_math_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(v2_q) && $past(v1_q, 2)) |->
      (sum_q == (RW'($past(ra_q, 2)) * RW'($past(rb_q, 2)) + RW'($past(rc_q)))));
endmodule

// File: rtl/mac_batch_mon.sv
module mac_batch_mon
  import mac_pkg::*;
#(
  parameter int unsigned N   = DEF_TASKS,
  localparam int unsigned IW = idx_width(N),
  localparam int unsigned TW = $clog2(N + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          res_v,
  input  logic [IW-1:0] res_idx,
  output logic          done,
  output logic [TW-1:0] cycles
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    done_d = res_v && (res_idx == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done   = done_q;
  assign cycles = cnt_q;

  // R6
  cycles_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == TW'(N + 2)));
endmodule

// File: rtl/mac_batch_top.sv
module mac_batch_top
  import mac_pkg::*;
#(
  parameter int unsigned N    = DEF_TASKS,
  parameter int unsigned AB_W = DEF_AB_W,
  parameter int unsigned C_W  = DEF_C_W,
  localparam int unsigned IW  = idx_width(N),
  localparam int unsigned RW  = sum_width(AB_W, C_W),
  localparam int unsigned TW  = $clog2(N + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [AB_W-1:0] wr_a,
  input  logic [AB_W-1:0] wr_b,
  input  logic [C_W-1:0]  wr_c,
  input  logic            start,
  output logic            res_valid,
  output logic [IW-1:0]   res_idx,
  output logic [RW-1:0]   res_data,
  output logic            done,
  output logic [TW-1:0]   cycles
);
  logic            start_acc, issue_v, inner_busy;
  logic [IW-1:0]   issue_idx;
  logic [AB_W-1:0] issue_a, issue_b;
  logic [C_W-1:0]  late_c;

  mac_seq #(.N(N), .AB_W(AB_W), .C_W(C_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .start(start),
    .start_acc(start_acc), .issue_v(issue_v), .issue_idx(issue_idx),
    .issue_a(issue_a), .issue_b(issue_b), .late_c(late_c)
  );

  mac_pipe3 #(.N(N), .AB_W(AB_W), .C_W(C_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(issue_v), .in_idx(issue_idx),
    .in_a(issue_a), .in_b(issue_b), .in_c(late_c),
    .inner_busy(inner_busy), .out_v(res_valid), .out_idx(res_idx),
    .out_sum(res_data)
  );

  mac_batch_mon #(.N(N)) u_mon (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .inc(issue_v | inner_busy),
    .res_v(res_valid), .res_idx(res_idx), .done(done), .cycles(cycles)
  );

  // R3
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(issue_v, 3));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> (res_idx == IW'($past(res_idx) + 1'b1)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!res_valid && $past(res_valid)));
endmodule

// File: tb/mac_batch_top_test.sv
module mac_batch_top_test;
  localparam int N = 7;

  logic        clk, rst_n, wr_en, start;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_a, wr_b;
  logic [15:0] wr_c;
  logic        res_valid, done;
  logic [2:0]  res_idx;
  logic [16:0] res_data;
  logic [3:0]  cycles;

  int checks = 0;
  int fails  = 0;
  int ta [N];
  int tb [N];
  int tc [N];

  mac_batch_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .start(start),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
    .done(done), .cycles(cycles)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int expect_sum(int a, int b, int c);
    return a * b + c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_ops();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en  = 1'b1;
      wr_idx = 3'(i);
      wr_a   = 8'(ta[i]);
      wr_b   = 8'(tb[i]);
      wr_c   = 16'(tc[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_batch(input bit poke_start);
    load_ops();  // R8 operands written here are the ones expected below
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= N + 5; k++) begin
      @(negedge clk);
      if (k >= 3 && k <= N + 2) begin
        chk(res_valid === 1'b1, "R3/R4 res_valid", int'(res_valid), 1);
        chk(res_idx === 3'(k - 3), "R4 res_idx", int'(res_idx), k - 3);
        chk(res_data === 17'(expect_sum(ta[k-3], tb[k-3], tc[k-3])), "R2/R8 res_data",
            int'(res_data), expect_sum(ta[k-3], tb[k-3], tc[k-3]));
      end else begin
        chk(res_valid === 1'b0, "R4 res_valid idle", int'(res_valid), 0);
      end
      chk(done === (k == N + 3), "R5 done", int'(done), int'(k == N + 3));
      if (k == N + 3) chk(cycles === 4'(N + 2), "R6 cycles", int'(cycles), N + 2);
      if (k == N + 5) chk(cycles === 4'(N + 2), "R6 cycles hold", int'(cycles), N + 2);
      // R7: extra start pulses while the batch is being issued
      start = poke_start && (k == 1 || k == 4);
    end
    start = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0;
    wr_idx = '0; wr_a = '0; wr_b = '0; wr_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(done === 1'b0, "R1 done", int'(done), 0);
    chk(cycles === 4'd0, "R1 cycles", int'(cycles), 0);

    // R2 maximum operands: 255*255+65535 = 130560
    for (int i = 0; i < N; i++) begin ta[i] = 255; tb[i] = 255; tc[i] = 65535; end
    run_batch(1'b0);
    // all zero
    for (int i = 0; i < N; i++) begin ta[i] = 0; tb[i] = 0; tc[i] = 0; end
    run_batch(1'b0);
    // index-distinct pattern, so any pairing slip shows
    for (int i = 0; i < N; i++) begin ta[i] = i + 1; tb[i] = 10 * (i + 1); tc[i] = 1000 * (i + 1); end
    run_batch(1'b1);  // R7
    // random batches
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        ta[i] = int'($urandom_range(0, 255));
        tb[i] = int'($urandom_range(0, 255));
        tc[i] = int'($urandom_range(0, 65535));
      end
      run_batch(r[0]);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule